// File: doc/BRIEF.md
# Multi-Mode General Purpose Timer

This block holds a bank of identical timers. Each timer owns one pad pin and can act as a pulse-width-modulated output, as a pulse-width and period measurement unit on that pin, or as a watchdog that expects activity on the pin. Software selects the behaviour of each timer through a small configuration register. Each timer also has a free-running count register and two 32-bit registers that hold either programmed values (output mode) or captured values (measurement mode).

All timers share one enable register, with one bit per timer, and one sticky status register. The status register holds a pending bit and a watchdog overflow bit for each timer. Each timer drives an interrupt line whenever its pending bit is set and its interrupt enable is on. Software reaches every register through a single-cycle write port and a combinational read port. The address is the timer index in the upper bits, followed by a 3-bit register select in the low bits.

The pad is bidirectional: the block drives `pinOut` and its enable `pinOe`, and it receives the pad level on `pinIn` through a synchronizer that is `SYNC_STAGES` flops deep.

Top module: `multimode_timer`

## Requirements
- R1: After reset every register reads zero, and all `irq` and `pinOe` bits are low.
- R2: Register select values are: 0 configuration, 1 count, 2 period, 3 width, 4 enable (global), 5 status (global). A write takes effect at the clock edge, and the written value appears on `rdData` for the same address in the next cycle. Configuration bits [5:4] are reserved and read as zero.
- R3: A timer whose enable bit is 0, or whose mode field is 00, holds its count at zero, and software writes to its count are ignored.
- R4: In mode 01 (configuration bits [1:0]) the count goes up by one per clock and returns to zero after reaching period-1. Each return to zero sets the timer's pending bit, which is status bit t.
- R5: In mode 01 the pin level is (count < width). Configuration bit 2 inverts that level.
- R6: In mode 10 the period register captures the clocks between consecutive rising pin edges, and the width register captures the clocks the pin stayed high.
- R7: In mode 10 the first rising edge after enabling sets no pending bit. Every later rising edge sets it.
- R8: In mode 11 any pin edge reloads the count to zero. When period clocks pass with no edge, both the pending bit and the overflow bit (status bit NUM_TIMERS+t) are set. No other mode sets the overflow bit.
- R9: Status bits are cleared by writing 1 to them. Writing 0 leaves them unchanged. Status bits never clear by themselves.
- R10: `irq[t]` is high exactly when pending bit t is set and configuration bit 3 of timer t is 1.
- R11: Enable register bit t enables timer t alone. Bits at or above NUM_TIMERS are dropped.
- R12: `pinOe[t]` is high only while timer t is enabled in mode 01. Otherwise the pad is left to the outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | {timer index, register select[2:0]} |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data for `addr`, combinational |
| pinIn | input | NUM_TIMERS | Pad level per timer |
| pinOut | output | NUM_TIMERS | Pad drive value per timer |
| pinOe | output | NUM_TIMERS | Pad output enable per timer |
| irq | output | NUM_TIMERS | Interrupt per timer |

## Verification
A register write is visible on the combinational read port in the cycle after the write edge. The bench therefore reads one negative edge after each write. The pad input passes through SYNC_STAGES+1 flops before edge detection, so each capture or watchdog result is due that many cycles after the pin changes. The bench waits at least five cycles past any pin change before it reads period, width or status. The bench checks PWM duty by counting high samples over a window that spans whole periods, so the result does not depend on the start phase. It checks the count step by reading the count twice, a known number of cycles apart.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  localparam int CFG_W       = 6;
  localparam int REG_SEL_W   = 3;
  localparam int CFG_POL_BIT = 2;
  localparam int CFG_IEN_BIT = 3;
  localparam logic [CFG_W-1:0] CFG_MASK = 6'b00_1111;

  localparam logic [REG_SEL_W-1:0] SEL_CFG    = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_COUNT  = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_PERIOD = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_WIDTH  = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_ENABLE = 3'd4;
  localparam logic [REG_SEL_W-1:0] SEL_STATUS = 3'd5;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_PWM     = 2'b01,
    MODE_CAPTURE = 2'b10,
    MODE_WDOG    = 2'b11
  } timerMode_e;

  // control -> datapath strobes, one set per timer
  typedef struct packed {
    logic       run;
    timerMode_e mode;
    logic       invert;
    logic       wrCount;
    logic       wrPeriod;
    logic       wrWidth;
  } timerStrobe_t;

endpackage

// File: rtl/mmt_ctrl.sv
module mmt_ctrl import mmt_pkg::*; #(
  parameter int NUM_TIMERS = 3,
  parameter int CNT_W      = 32,
  parameter int SEL_W      = 2,
  parameter int CTRL_W     = 6,
  localparam int ADDR_W    = SEL_W + REG_SEL_W
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  wrEn,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [CTRL_W-1:0]                     wrData,
  output logic [CNT_W-1:0]                      rdData,
  output timerStrobe_t [NUM_TIMERS-1:0]         strobeVec,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      cntVec,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      perVec,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      widVec,
  input  logic [NUM_TIMERS-1:0]                 evtVec,
  input  logic [NUM_TIMERS-1:0]                 ovfVec,
  output logic [2*NUM_TIMERS-1:0]               statusVec,
  output logic [NUM_TIMERS-1:0]                 irq
);

  logic [SEL_W-1:0]      tIdx;
  logic [REG_SEL_W-1:0]  regSel;
  logic [CFG_W-1:0]      cfgReg [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] enableReg;
  logic [NUM_TIMERS-1:0] pendReg;
  logic [NUM_TIMERS-1:0] ovfReg;
  logic                  statWr;
  logic [NUM_TIMERS-1:0] pendClr;
  logic [NUM_TIMERS-1:0] ovfClr;

  assign tIdx   = addr[ADDR_W-1:REG_SEL_W];
  assign regSel = addr[REG_SEL_W-1:0];

  assign statWr  = wrEn && (regSel == SEL_STATUS);
  assign pendClr = statWr ? wrData[NUM_TIMERS-1:0] : '0;
  assign ovfClr  = statWr ? wrData[2*NUM_TIMERS-1:NUM_TIMERS] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TIMERS; t++) cfgReg[t] <= '0;
      enableReg <= '0;
      pendReg   <= '0;
      ovfReg    <= '0;
    end else begin
      for (int t = 0; t < NUM_TIMERS; t++) begin
        if (wrEn && (regSel == SEL_CFG) && (int'(tIdx) == t))
          cfgReg[t] <= wrData[CFG_W-1:0] & CFG_MASK;
      end
      if (wrEn && (regSel == SEL_ENABLE))
        enableReg <= wrData[NUM_TIMERS-1:0];
      // a new event wins over a clear in the same cycle
      pendReg <= (pendReg & ~pendClr) | evtVec;
      ovfReg  <= (ovfReg & ~ovfClr) | ovfVec;
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_TIMERS; t++) begin
      logic hitT;
      hitT = wrEn && (int'(tIdx) == t);
      strobeVec[t].run      = enableReg[t] && (cfgReg[t][1:0] != MODE_OFF);
      strobeVec[t].mode     = timerMode_e'(cfgReg[t][1:0]);
      strobeVec[t].invert   = cfgReg[t][CFG_POL_BIT];
      strobeVec[t].wrCount  = hitT && (regSel == SEL_COUNT);
      strobeVec[t].wrPeriod = hitT && (regSel == SEL_PERIOD);
      strobeVec[t].wrWidth  = hitT && (regSel == SEL_WIDTH);
      irq[t]                = pendReg[t] & cfgReg[t][CFG_IEN_BIT];
    end
  end

  assign statusVec = {ovfReg, pendReg};

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_ENABLE: rdData[NUM_TIMERS-1:0]   = enableReg;
      SEL_STATUS: rdData[2*NUM_TIMERS-1:0] = {ovfReg, pendReg};
      default: begin
        for (int t = 0; t < NUM_TIMERS; t++) begin
          if (int'(tIdx) == t) begin
            case (regSel)
              SEL_CFG:    rdData[CFG_W-1:0] = cfgReg[t];
              SEL_COUNT:  rdData = cntVec[t];
              SEL_PERIOD: rdData = perVec[t];
              SEL_WIDTH:  rdData = widVec[t];
              default:    rdData = '0;
            endcase
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/mmt_datapath.sv
module mmt_datapath import mmt_pkg::*; #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerStrobe_t     strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOe,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] width,
  output logic             evtPulse,
  output logic             ovfPulse
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevIn;
  logic                   lvl, prevLvl, rise, fall, anyEdge;
  logic [CNT_W-1:0]       hiCnt, hiNext;
  logic                   seenRise, seenNext;
  logic [CNT_W-1:0]       cntNext, perNext, widNext;
  logic                   lastTick;
  logic                   pwmActive;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= 1'b0;
    else       prevIn <= syncChain[SYNC_STAGES-1];
  end

  assign lvl     = syncChain[SYNC_STAGES-1] ^ strobe.invert;
  assign prevLvl = prevIn ^ strobe.invert;
  assign rise    = lvl && !prevLvl;
  assign fall    = !lvl && prevLvl;
  assign anyEdge = lvl ^ prevLvl;

  assign lastTick = (period == '0) || (count >= period - CNT_W'(1));

  always_comb begin
    cntNext  = count;
    perNext  = period;
    widNext  = width;
    hiNext   = hiCnt;
    seenNext = seenRise;
    evtPulse = 1'b0;
    ovfPulse = 1'b0;
    if (!strobe.run) begin
      cntNext  = '0;
      hiNext   = '0;
      seenNext = 1'b0;
    end else begin
      case (strobe.mode)
        MODE_PWM: begin
          if (lastTick) begin
            cntNext  = '0;
            evtPulse = 1'b1;
          end else begin
            cntNext = count + CNT_W'(1);
          end
        end
        MODE_CAPTURE: begin
          cntNext = count + CNT_W'(1);
          if (lvl && !rise) hiNext = hiCnt + CNT_W'(1);
          if (rise) begin
            cntNext  = '0;
            hiNext   = CNT_W'(1);
            seenNext = 1'b1;
            if (seenRise) begin
              perNext  = count + CNT_W'(1);
              evtPulse = 1'b1;
            end
          end
          if (fall) widNext = hiCnt;
        end
        MODE_WDOG: begin
          if (anyEdge) begin
            cntNext = '0;
          end else if (lastTick) begin
            cntNext  = '0;
            evtPulse = 1'b1;
            ovfPulse = 1'b1;
          end else begin
            cntNext = count + CNT_W'(1);
          end
        end
        default: cntNext = '0;
      endcase
      if (strobe.wrCount) cntNext = wrData;
    end
    if (strobe.wrPeriod) perNext = wrData;
    if (strobe.wrWidth)  widNext = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      period   <= '0;
      width    <= '0;
      hiCnt    <= '0;
      seenRise <= 1'b0;
    end else begin
      count    <= cntNext;
      period   <= perNext;
      width    <= widNext;
      hiCnt    <= hiNext;
      seenRise <= seenNext;
    end
  end

  assign pwmActive = strobe.run && (strobe.mode == MODE_PWM);
  assign pinOe     = pwmActive;
  assign pinOut    = pwmActive && ((count < width) ^ strobe.invert);

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer import mmt_pkg::*; #(
  parameter int NUM_TIMERS  = 3,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W     = SEL_W + REG_SEL_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  input  logic [NUM_TIMERS-1:0] pinIn,
  output logic [NUM_TIMERS-1:0] pinOut,
  output logic [NUM_TIMERS-1:0] pinOe,
  output logic [NUM_TIMERS-1:0] irq
);

  localparam int CTRL_W = (2*NUM_TIMERS > CFG_W) ? 2*NUM_TIMERS : CFG_W;

  timerStrobe_t [NUM_TIMERS-1:0]     strobeVec;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cntVec, perVec, widVec;
  logic [NUM_TIMERS-1:0]             evtVec, ovfVec;
  logic [2*NUM_TIMERS-1:0]           statusVec;
  logic [NUM_TIMERS-1:0]             runVec;
  timerMode_e [NUM_TIMERS-1:0]       modeVec;

  mmt_ctrl #(
    .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .SEL_W(SEL_W), .CTRL_W(CTRL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData[CTRL_W-1:0]), .rdData(rdData),
    .strobeVec(strobeVec), .cntVec(cntVec), .perVec(perVec), .widVec(widVec),
    .evtVec(evtVec), .ovfVec(ovfVec), .statusVec(statusVec), .irq(irq)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    mmt_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
      .clk(clk), .rstN(rstN), .strobe(strobeVec[t]), .wrData(wrData),
      .pinIn(pinIn[t]), .pinOut(pinOut[t]), .pinOe(pinOe[t]),
      .count(cntVec[t]), .period(perVec[t]), .width(widVec[t]),
      .evtPulse(evtVec[t]), .ovfPulse(ovfVec[t])
    );
    assign runVec[t]  = strobeVec[t].run;
    assign modeVec[t] = strobeVec[t].mode;
  end

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker import mmt_pkg::*; #(
  parameter int NUM_TIMERS = 3,
  parameter int CNT_W      = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             wrEn,
  input logic [NUM_TIMERS-1:0]            runVec,
  input timerMode_e [NUM_TIMERS-1:0]      modeVec,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] perVec,
  input logic [NUM_TIMERS-1:0]            evtVec,
  input logic [2*NUM_TIMERS-1:0]          statusVec,
  input logic [NUM_TIMERS-1:0]            pinOe,
  input logic [NUM_TIMERS-1:0]            irq
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (irq == '0) && (pinOe == '0));

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chk
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
      !runVec[t] |=> (cntVec[t] == '0));

    assert_pwm_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[t] && (modeVec[t] == MODE_PWM) && (perVec[t] != '0) &&
       (cntVec[t] >= perVec[t] - CNT_W'(1)) && !wrEn) |=> (cntVec[t] == '0));

    assert_pend_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusVec[t]) |-> $past(evtVec[t]));

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusVec[t]) |-> $past(wrEn));

    assert_ovf_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusVec[NUM_TIMERS+t]) |-> ($past(modeVec[t]) == MODE_WDOG));

    assert_oe_after_write_R12: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pinOe[t]) |-> $past(wrEn));
  end

endmodule

bind multimode_timer mmt_checker #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) u_mmtChecker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .runVec(runVec), .modeVec(modeVec),
  .cntVec(cntVec), .perVec(perVec), .evtVec(evtVec), .statusVec(statusVec),
  .pinOe(pinOe), .irq(irq)
);

// File: tb/multimode_timer_bench.sv
`timescale 1ns/1ps
module multimode_timer_bench;

  localparam int NT = 3;
  localparam logic [4:0] A_ENABLE = 5'h04;
  localparam logic [4:0] A_STATUS = 5'h05;

  typedef struct packed {
    logic [1:0]  kind;   // 0: R2, 1: R3, 2: R11
    logic [4:0]  ad;
    logic [31:0] wd;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'h00, 32'h0000_003F, 32'h0000_000F},
    '{2'd0, 5'h02, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{2'd0, 5'h0B, 32'h0000_1234, 32'h0000_1234},
    '{2'd1, 5'h11, 32'h0000_0005, 32'h0000_0000},
    '{2'd0, 5'h10, 32'h0000_002B, 32'h0000_000B},
    '{2'd0, 5'h12, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd2, 5'h04, 32'h0000_00F8, 32'h0000_0000}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NT-1:0] pinIn = '0;
  logic [NT-1:0] pinOut, pinOe, irq;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  multimode_timer u_multimode_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  function automatic logic [4:0] ta(input int idx, input int sel);
    return 5'((idx << 3) | sel);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ad; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ad, output logic [31:0] v);
    addr = ad;
    #1;
    v = rdData;
  endtask

  task automatic pulse(input int idx, input int hi, input int lo);
    @(negedge clk);
    pinIn[idx] = 1'b1;
    repeat (hi) @(negedge clk);
    pinIn[idx] = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, c1, c2;
    int highs;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(ta(0, 0), v); check("R1 cfg0", v, 32'h0);
    rd(ta(1, 1), v); check("R1 count1", v, 32'h0);
    rd(ta(2, 2), v); check("R1 period2", v, 32'h0);
    rd(A_STATUS, v); check("R1 status", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 pinOe", 32'(pinOe), 32'h0);

    // register table walk
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].ad, VECS[i].wd);
      rd(VECS[i].ad, v);
      case (VECS[i].kind)
        2'd1:    check("R3 table", v, VECS[i].ex);
        2'd2:    check("R11 table", v, VECS[i].ex);
        default: check("R2 table", v, VECS[i].ex);
      endcase
    end

    // PWM on timer 0, timer 1 configured but left disabled
    wr(A_STATUS, 32'hFFFF_FFFF);
    wr(ta(0, 0), 32'h9);
    wr(ta(0, 2), 32'd10);
    wr(ta(0, 3), 32'd3);
    wr(ta(1, 0), 32'h1);
    wr(A_ENABLE, 32'h1);
    repeat (5) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      highs += int'(pinOut[0]);
    end
    check("R5 duty", 32'(highs), 32'd6);
    check("R12 oe active", 32'(pinOe[0]), 32'h1);
    check("R12 oe idle", 32'(pinOe[1]), 32'h0);
    rd(ta(1, 1), v); check("R11 other count", v, 32'h0);
    @(negedge clk); rd(ta(0, 1), c1);
    repeat (3) @(negedge clk); rd(ta(0, 1), c2);
    check("R4 step", c2, (c1 + 32'd3) % 32'd10);
    check("R4 range", 32'(c1 < 32'd10), 32'h1);
    rd(A_STATUS, v); check("R4 wrap pending", v & 32'h1, 32'h1);
    check("R10 irq on", 32'(irq[0]), 32'h1);

    wr(ta(0, 0), 32'hD);
    repeat (5) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      highs += int'(pinOut[0]);
    end
    check("R5 inverted duty", 32'(highs), 32'd14);

    wr(A_ENABLE, 32'h0);
    @(negedge clk);
    rd(ta(0, 1), v); check("R3 disabled count", v, 32'h0);
    check("R12 oe disabled", 32'(pinOe[0]), 32'h0);
    wr(ta(0, 0), 32'h5);
    check("R10 irq masked", 32'(irq[0]), 32'h0);
    wr(A_STATUS, 32'h0);
    rd(A_STATUS, v); check("R9 write zero", v & 32'h1, 32'h1);
    wr(A_STATUS, 32'h1);
    rd(A_STATUS, v); check("R9 write one", v, 32'h0);

    // capture on timer 1
    wr(ta(1, 0), 32'hA);
    wr(A_ENABLE, 32'h2);
    pulse(1, 4, 8);
    repeat (5) @(negedge clk);
    rd(A_STATUS, v); check("R7 first rise", v, 32'h0);
    pulse(1, 4, 8);
    repeat (5) @(negedge clk);
    rd(A_STATUS, v); check("R7 second rise", v & 32'h2, 32'h2);
    check("R10 capture irq", 32'(irq[1]), 32'h1);
    rd(ta(1, 3), v); check("R6 width a", v, 32'd4);
    rd(ta(1, 2), v); check("R6 period a", v, 32'd17);
    pulse(1, 6, 9);
    pulse(1, 3, 3);
    repeat (6) @(negedge clk);
    rd(ta(1, 3), v); check("R6 width b", v, 32'd3);
    rd(ta(1, 2), v); check("R6 period b", v, 32'd15);

    // watchdog on timer 2
    wr(ta(2, 2), 32'd20);
    wr(ta(2, 0), 32'hB);
    wr(A_ENABLE, 32'h4);
    wr(A_STATUS, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      repeat (8) @(negedge clk);
      pinIn[2] = ~pinIn[2];
    end
    repeat (4) @(negedge clk);
    rd(A_STATUS, v); check("R8 fed", v, 32'h0);
    check("R12 oe watchdog", 32'(pinOe[2]), 32'h0);
    repeat (30) @(negedge clk);
    rd(A_STATUS, v); check("R8 starved", v, 32'h24);
    check("R10 watchdog irq", 32'(irq[2]), 32'h1);

    finishRun();
  end

endmodule